// File: doc/BRIEF.md
# Endian Byte-Lane Reordering Unit

This block sits between a processor core and its memory bus. It gives every access a little-endian or big-endian attribute. For accesses to little-endian regions it swaps the byte lanes of the transferred data, so the core always sees big-endian values. The address is never altered. Only the placement of bytes on the data lanes changes.

Each request carries the following:

- a kind: instruction fetch, data load or data store;
- an address and an access size;
- the instruction-translation and data-translation enable bits;
- the endian bit of the page entry that translation found;
- one data word with its byte enables. For a fetch this is the word returned by memory, for a load it is the returned data, and for a store it is the core's write data.

A 32-bit real-mode region register, written through a write strobe, supplies the attribute when both translation bits are off. The attribute decision and the lane steering are combinational. All results leave through one register stage.

Fetched words in little-endian regions have all four bytes reversed before they reach the instruction cache, so the cache always holds big-endian instructions. Load and store data in little-endian regions is reversed only within the accessed operand.

Top module: `endian_lane_unit`

## Requirements
- R1: `le_o` reports the attribute of the registered access: 0 means big endian and 1 means little endian.
- R2: If `xlat_instr_en_i` or `xlat_data_en_i` is 1, the attribute equals `page_le_i`.
- R3: If both translation enables are 0, the attribute is bit k of the region register, where k is `req_addr_i[31:27]` (bit 0 covers the lowest 128 MiB).
  - The register resets to 0 and loads `region_le_wdata_i` when `region_le_wr_i` is 1.
  - A request in the same cycle as a write still sees the old value.
- R4: `addr_o`, `kind_o` and `size_o` equal the request's address, kind (0 fetch, 1 load, 2 store) and size (0 byte, 1 halfword, 2 word) with no modification.
- R5: A little-endian fetch reverses all four bytes of the word, whatever the size input.
  - `data_i[31:24]` holds the byte at address offset 0, and byte enable bit k covers `data_i[8k+7:8k]`.
  - For example, bytes 14 22 E7 7C at offsets 0 to 3 come out as 32'h7CE72214.
- R6: A big-endian fetch passes the word unchanged.
- R7: A little-endian halfword load or store swaps the two bytes of the halfword selected by address bit 1. The other two lanes pass unchanged.
- R8: A little-endian word load or store reverses all four bytes.
- R9: A byte load or store passes data unchanged in either endian mode.
- R10: Byte enables are mirrored within the same operand span as the data. They pass unchanged outside that span and in big-endian accesses.
- R11: All outputs are registered, so results appear one clock after the request. `valid_o` follows `req_valid_i` by one cycle, and every output is 0 in reset.
- R12: A big-endian load or store passes data and byte enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 2 | 0 fetch, 1 load, 2 store |
| req_addr_i | input | 32 | Access address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| xlat_instr_en_i | input | 1 | Instruction translation enabled |
| xlat_data_en_i | input | 1 | Data translation enabled |
| page_le_i | input | 1 | Endian bit of the matching translation entry |
| region_le_wr_i | input | 1 | Region register write strobe |
| region_le_wdata_i | input | 32 | Region register write value |
| data_i | input | 32 | Fetched word, load return or store data |
| be_i | input | 4 | Byte enables for data_i |
| valid_o | output | 1 | Registered request valid |
| kind_o | output | 2 | Registered kind |
| addr_o | output | 32 | Registered address, unmodified |
| size_o | output | 2 | Registered size |
| le_o | output | 1 | Effective endian attribute |
| data_o | output | 32 | Lane-steered data |
| be_o | output | 4 | Lane-steered byte enables |

## Verification
Every result of a request (attribute, address, steered data and byte enables) is due on the first rising edge after the request is presented. A region register write affects only requests presented from the next cycle on.

The bench drives each request on a falling edge and records the expected outputs from its own model at that moment. It compares them with the outputs on the following falling edge, half a period after the capturing edge. Requests that overlap a register write are checked against the register value from before the write.

// File: rtl/endian_pkg.sv
package endian_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SIZE_BYTE = 2'd0,
    SIZE_HALF = 2'd1,
    SIZE_WORD = 2'd2,
    SIZE_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/endian_attr_sel.sv
module endian_attr_sel #(
  parameter int REGION_BITS = 5,
  localparam int NREG = 1 << REGION_BITS
) (
  input  logic [REGION_BITS-1:0] region_idx_i,
  input  logic                   xlat_instr_en_i,
  input  logic                   xlat_data_en_i,
  input  logic                   page_le_i,
  input  logic [NREG-1:0]        region_le_i,
  output logic                   le_o
);
  // translation on: page entry wins; real mode: region register
  assign le_o = (xlat_instr_en_i || xlat_data_en_i) ? page_le_i : region_le_i[region_idx_i];
endmodule

// File: rtl/endian_lane_swap.sv
module endian_lane_swap
  import endian_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int OFF_W = $clog2(BYTES),
  localparam int DW = BYTES * 8
) (
  input  logic             le_i,
  input  logic [1:0]       kind_i,
  input  logic [1:0]       size_i,
  input  logic [OFF_W-1:0] offs_i,
  input  logic [DW-1:0]    data_i,
  input  logic [BYTES-1:0] be_i,
  output logic [DW-1:0]    data_o,
  output logic [BYTES-1:0] be_o
);
  int span_log, span, base;

  always_comb begin
    span_log = (kind_i == KIND_FETCH) ? OFF_W : int'(size_i);
    if (span_log > OFF_W) span_log = OFF_W;
    span = 1 << span_log;
    base = int'(offs_i) & ~(span - 1);
  end

  // byte offset b lives in lane BYTES-1-b (offset 0 on the top lane)
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    int src;
    always_comb begin
      src = b;
      if (le_i && b >= base && b < base + span) src = 2 * base + span - 1 - b;
      data_o[(BYTES-1-b)*8 +: 8] = data_i[(BYTES-1-src)*8 +: 8];
      be_o[BYTES-1-b]            = be_i[BYTES-1-src];
    end
  end
endmodule

// File: rtl/endian_lane_unit.sv
module endian_lane_unit
  import endian_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REGION_BITS = 5,
  localparam int NREG = 1 << REGION_BITS,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              xlat_instr_en_i,
  input  logic              xlat_data_en_i,
  input  logic              page_le_i,
  input  logic              region_le_wr_i,
  input  logic [NREG-1:0]   region_le_wdata_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BYTES-1:0]  be_i,
  output logic              valid_o,
  output logic [1:0]        kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        size_o,
  output logic              le_o,
  output logic [DATA_W-1:0] data_o,
  output logic [BYTES-1:0]  be_o
);
  logic [NREG-1:0]   region_q;
  logic              le_d;
  logic [DATA_W-1:0] data_d;
  logic [BYTES-1:0]  be_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) region_q <= '0;
    else if (region_le_wr_i) region_q <= region_le_wdata_i;
  end

  endian_attr_sel #(.REGION_BITS(REGION_BITS)) u_attr (
    .region_idx_i    (req_addr_i[ADDR_W-1 -: REGION_BITS]),
    .xlat_instr_en_i (xlat_instr_en_i),
    .xlat_data_en_i  (xlat_data_en_i),
    .page_le_i       (page_le_i),
    .region_le_i     (region_q),
    .le_o            (le_d)
  );

  endian_lane_swap #(.BYTES(BYTES)) u_swap (
    .le_i   (le_d),
    .kind_i (req_kind_i),
    .size_i (req_size_i),
    .offs_i (req_addr_i[OFF_W-1:0]),
    .data_i (data_i),
    .be_i   (be_i),
    .data_o (data_d),
    .be_o   (be_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      kind_o  <= '0;
      addr_o  <= '0;
      size_o  <= '0;
      le_o    <= 1'b0;
      data_o  <= '0;
      be_o    <= '0;
    end else begin
      valid_o <= req_valid_i;
      if (req_valid_i) begin
        kind_o <= req_kind_i;
        addr_o <= req_addr_i;
        size_o <= req_size_i;
        le_o   <= le_d;
        data_o <= data_d;
        be_o   <= be_d;
      end
    end
  end
endmodule

// File: rtl/endian_lane_unit_chk.sv
module endian_lane_unit_chk
  import endian_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_kind_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              xlat_instr_en_i,
  input logic              xlat_data_en_i,
  input logic              page_le_i,
  input logic [DATA_W-1:0] data_i,
  input logic [BYTES-1:0]  be_i,
  input logic              valid_o,
  input logic [1:0]        kind_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        size_o,
  input logic              le_o,
  input logic [DATA_W-1:0] data_o,
  input logic [BYTES-1:0]  be_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else past_ok <= 1'b1;
  end

  function automatic logic [DATA_W-1:0] rev_bytes(input logic [DATA_W-1:0] d);
    for (int i = 0; i < BYTES; i++) rev_bytes[i*8 +: 8] = d[(BYTES-1-i)*8 +: 8];
  endfunction

  // R11
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> valid_o == $past(req_valid_i));

  // R4
  addr_kind_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && valid_o |-> addr_o == $past(req_addr_i) && kind_o == $past(req_kind_i));

  // R2
  page_attr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && valid_o && ($past(xlat_instr_en_i) || $past(xlat_data_en_i)) |-> le_o == $past(page_le_i));

  // R12
  big_endian_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && valid_o && !le_o |-> data_o == $past(data_i) && be_o == $past(be_i));

  // R9
  byte_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && valid_o && kind_o != KIND_FETCH && size_o == SIZE_BYTE |-> data_o == $past(data_i));

  // R5
  fetch_rev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && valid_o && le_o && kind_o == KIND_FETCH |-> data_o == rev_bytes($past(data_i)));
endmodule

bind endian_lane_unit endian_lane_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
  .req_addr_i(req_addr_i), .xlat_instr_en_i(xlat_instr_en_i), .xlat_data_en_i(xlat_data_en_i),
  .page_le_i(page_le_i), .data_i(data_i), .be_i(be_i), .valid_o(valid_o), .kind_o(kind_o),
  .addr_o(addr_o), .size_o(size_o), .le_o(le_o), .data_o(data_o), .be_o(be_o)
);

// File: tb/endian_lane_unit_test.sv
module endian_lane_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_kind_i = '0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        xlat_instr_en_i = 1'b0;
  logic        xlat_data_en_i = 1'b0;
  logic        page_le_i = 1'b0;
  logic        region_le_wr_i = 1'b0;
  logic [31:0] region_le_wdata_i = '0;
  logic [31:0] data_i = '0;
  logic [3:0]  be_i = '0;
  logic        valid_o;
  logic [1:0]  kind_o;
  logic [31:0] addr_o;
  logic [1:0]  size_o;
  logic        le_o;
  logic [31:0] data_o;
  logic [3:0]  be_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  endian_lane_unit uut (.*);

  always #10 clk_i = ~clk_i;

  // model state
  logic [31:0] region_m = '0;
  bit          e_valid = 0;
  logic [1:0]  e_kind;
  logic [31:0] e_addr;
  logic [1:0]  e_size;
  logic        e_le;
  logic [31:0] e_data;
  logic [3:0]  e_be;
  string       e_le_tag, e_dat_tag;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R11 valid", 32'(valid_o), 32'(e_valid));
    if (e_valid) begin
      chk("R4 addr", addr_o, e_addr);
      chk("R4 kind/size", {28'd0, kind_o, size_o}, {28'd0, e_kind, e_size});
      chk(e_le_tag, 32'(le_o), 32'(e_le));
      chk(e_dat_tag, data_o, e_data);
      chk("R10 byte enables", 32'(be_o), 32'(e_be));
    end
  endtask

  task automatic step(bit v, logic [1:0] k, logic [31:0] a, logic [1:0] s, bit xi, bit xd,
                      bit ple, logic [31:0] d, logic [3:0] be, bit wr, logic [31:0] wd);
    int n, base;
    logic [7:0] q[$];
    bit qb[$];
    @(negedge clk_i);
    compare();
    req_valid_i = v; req_kind_i = k; req_addr_i = a; req_size_i = s;
    xlat_instr_en_i = xi; xlat_data_en_i = xd; page_le_i = ple;
    data_i = d; be_i = be; region_le_wr_i = wr; region_le_wdata_i = wd;
    e_valid = v;
    if (v) begin
      e_kind = k; e_addr = a; e_size = s;
      e_le = (xi || xd) ? ple : region_m[a[31:27]];
      e_le_tag = (xi || xd) ? "R1 R2 attribute" : "R1 R3 attribute";
      n = (k == 2'd0) ? 4 : (1 << s);
      base = int'(a[1:0]) & ~(n - 1);
      e_data = d; e_be = be;
      for (int i = 0; i < n; i++) begin
        q.push_back(d[31 - 8*(base+i) -: 8]);
        qb.push_back(be[3 - (base+i)]);
      end
      if (e_le) begin
        for (int i = 0; i < n; i++) begin
          e_data[31 - 8*(base+i) -: 8] = q.pop_back();
          e_be[3 - (base+i)] = qb.pop_back();
        end
      end
      if (!e_le) e_dat_tag = (k == 2'd0) ? "R6 fetch data" : "R12 data";
      else if (k == 2'd0) e_dat_tag = "R5 fetch data";
      else if (s == 2'd0) e_dat_tag = "R9 byte data";
      else if (s == 2'd1) e_dat_tag = "R7 half data";
      else e_dat_tag = "R8 word data";
    end
    if (wr) region_m = wd;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    #35;
    chk("R11 reset valid", 32'(valid_o), 0);
    chk("R11 reset data", data_o, 0);
    chk("R11 reset attr", 32'(le_o), 0);
    rst_ni = 1'b1;
    // fetch via page LE: example word
    step(1, 2'd0, 32'h0000_0000, 2'd2, 1, 0, 1, 32'h1422E77C, 4'hF, 0, 0);
    @(negedge clk_i);
    chk("R5 example 7CE72214", data_o, 32'h7CE72214);
    compare();
    step(1, 2'd0, 32'h0000_0004, 2'd0, 1, 0, 0, 32'h7CE72214, 4'hF, 0, 0);
    // program regions 0 and 31 little endian
    step(0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h8000_0001);
    step(1, 2'd1, 32'h0000_0010, 2'd2, 0, 0, 0, 32'h1122_3344, 4'hF, 0, 0);
    step(1, 2'd1, 32'h0800_0010, 2'd2, 0, 0, 1, 32'h1122_3344, 4'hF, 0, 0);
    step(1, 2'd2, 32'hF800_0002, 2'd1, 0, 0, 0, 32'h0000_ABCD, 4'h3, 0, 0);
    step(1, 2'd2, 32'hF800_0000, 2'd1, 0, 0, 0, 32'hABCD_5566, 4'hC, 0, 0);
    step(1, 2'd1, 32'h0000_0003, 2'd0, 0, 0, 0, 32'hDEAD_BE5A, 4'h1, 0, 0);
    step(1, 2'd1, 32'h0000_0020, 2'd2, 0, 1, 0, 32'hCAFE_F00D, 4'hF, 0, 0);
    step(1, 2'd2, 32'h0000_0002, 2'd1, 0, 0, 0, 32'h0000_1234, 4'h2, 0, 0);
    // write in same cycle as a request: old value applies
    step(1, 2'd1, 32'hF800_0100, 2'd2, 0, 0, 0, 32'h0102_0304, 4'hF, 1, 32'h0000_0002);
    step(1, 2'd1, 32'hF800_0100, 2'd2, 0, 0, 0, 32'h0102_0304, 4'hF, 0, 0);
    step(1, 2'd0, 32'h0800_0040, 2'd1, 0, 0, 0, 32'hA1B2_C3D4, 4'hF, 0, 0);
    for (int i = 0; i < 60; i++) begin
      x = 32'(i) * 32'h9E37_79B9 + 32'h1357_9BDF;
      step(i % 7 != 3, 2'(i % 3), {x[31:27], 25'(i * 4), x[1:0]}, 2'(i % 3), x[8], x[9] & x[8],
           x[10], x ^ 32'hA5A5_5A5A, x[15:12], i % 11 == 5, x);
    end
    step(0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk_i);
    compare();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule